// File: doc/BRIEF.md
# Kernel Launch Control and Interrupt Registers

This block sits between a host on an AXI4-Lite bus and one accelerator kernel. It holds a packed control word at offset 0x00, where each bit has its own access rule. The host starts the kernel by writing a 1 to the start bit, and the block turns that write into a single-cycle launch pulse. The block then watches for the kernel's finish pulse and keeps the running, idle, ready and done state. The done bit clears when the host reads it. If the auto-restart bit is set, the kernel is launched again without any further host write.

Three interrupt registers follow the control word: a global enable, a per-source enable and a sticky status register. The status register records kernel-finish and ready events, and the host clears it by writing ones. A single level interrupt line is raised while the global enable is on and any enabled status bit is set. The kernel datapath itself is not part of the block. Only its start and finish pulses cross the boundary.

Top module: `krn_ctrl_top`

## Requirements
- R1: After reset the control word at 0x00 reads 0x0000000C (bit 2 idle and bit 3 ready set, all others 0), the registers at 0x04, 0x08 and 0x0C read 0, and `irq` and `krn_start` are low.
- R2: A write to 0x00 with bit 0 set, with byte lane 0 enabled, while the kernel is idle and no launch is pending, sets the start bit. On the next cycle `krn_start` pulses high for exactly one cycle, the start bit clears and the kernel counts as running.
- R3: A `krn_done` pulse while running ends the run and sets done (bit 1). A host read of 0x00 returns the current done value and then clears it. A finish in the same cycle as the read wins.
- R4: Idle (bit 2) and ready (bit 3) both read 1 exactly when the kernel is not running, and both read 0 during a run.
- R5: A write of 1 to bit 0 while a run is in progress is ignored: no extra `krn_start` pulse follows, and the start bit reads 0.
- R6: Bit 7 (auto-restart) is read-write. While it is 1, each finished run sets the start bit and relaunches the kernel on the following cycle without a host write. Clearing it stops further relaunches.
- R7: Bits 4 to 6 and 8 to 31 of the control word read 0 and ignore writes. Writes to bits 1 to 3 have no effect. A write whose byte lane 0 strobe is 0 changes no register.
- R8: The global enable is bit 0 at 0x04. The interrupt enable is bits 1:0 at 0x08 (bit 0 for done, bit 1 for ready). Both are read-write, and their other bits read 0.
- R9: The status register at 0x0C latches bit 0 on each finish event and bit 1 on each ready event (running to idle), whatever the enables hold. Writing a 1 to a bit clears it. A new event in the same cycle wins over the clear.
- R10: `irq` is high exactly when the global enable is 1 and some status bit is set whose enable bit is also 1.
- R11: Reads of addresses from 0x10 upward return 0. Writes to them change nothing. Every response is OKAY (0).
- R12: A write is accepted when address and data are both valid, and it yields one write response that is held until `s_bready` is high. A read yields one data beat that is held until `s_rready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| krn_start | output | 1 | One-cycle kernel launch pulse |
| krn_done | input | 1 | One-cycle kernel finish pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check several rules on every cycle. The launch pulse never lasts longer than one cycle, and a launch always coincides with the running state. A start write during a run leaves the start bit clear, and a finish always sets done. The status bits stay set until a write-one clears them, the interrupt line never rises without an enabled status bit under the global enable, and a write response holds until it is taken. The bench scenarios cover what needs a run to complete: clear-on-read of done, the absence of a second launch after a start written while busy, the chain of relaunches under auto-restart and its end when the bit is cleared, and the interrupt line following enable and clear writes. The bench also checks unused bits, masked strobes and out-of-range addresses by reading the registers back.

// File: rtl/krn_ctrl_pkg.sv
package krn_ctrl_pkg;

    // control word bit positions (host software depends on these)
    localparam int CW_START = 0;
    localparam int CW_DONE  = 1;
    localparam int CW_IDLE  = 2;
    localparam int CW_READY = 3;
    localparam int CW_AUTO  = 7;

    // interrupt sources, index into enable/status registers
    localparam int IRQ_SRC_DONE  = 0;
    localparam int IRQ_SRC_READY = 1;
    localparam int IRQ_SRC_N     = 2;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // register select from address bits [3:2]
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_GIE  = 2'd1,
        SEL_IER  = 2'd2,
        SEL_ISR  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/krn_axil_if.sv
module krn_axil_if #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                rd_en,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]   rd_data
);
    import krn_ctrl_pkg::*;

    typedef struct packed {
        logic              bvalid;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     wr_fire, rd_fire;

    always_comb begin
        st_d      = st_q;
        wr_fire   = s_awvalid && s_wvalid && !st_q.bvalid;
        rd_fire   = s_arvalid && !st_q.rvalid;

        if (st_q.bvalid && s_bready) st_d.bvalid = 1'b0;
        if (wr_fire)                 st_d.bvalid = 1'b1;

        if (st_q.rvalid && s_rready) st_d.rvalid = 1'b0;
        if (rd_fire) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_data;
        end

        s_awready = wr_fire;
        s_wready  = wr_fire;
        s_arready = !st_q.rvalid;
        wr_en     = wr_fire && s_wstrb[0];
        wr_addr   = s_awaddr;
        wr_data   = s_wdata;
        rd_en     = rd_fire;
        rd_addr   = s_araddr;
        s_bvalid  = st_q.bvalid;
        s_bresp   = RESP_OKAY;
        s_rvalid  = st_q.rvalid;
        s_rdata   = st_q.rdata;
        s_rresp   = RESP_OKAY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/krn_ctrl_word.sv
module krn_ctrl_word #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [7:0]        wr_byte,
    input  logic              rd_ctrl,
    input  logic              krn_done,
    output logic              krn_start,
    output logic              running,
    output logic              start_bit,
    output logic              done_bit,
    output logic              done_evt,
    output logic              ready_evt,
    output logic [DATA_W-1:0] ctrl_word
);
    import krn_ctrl_pkg::*;

    typedef struct packed {
        logic start;
        logic running;
        logic done;
        logic auto_rs;
        logic kstart;
    } cw_st_t;

    cw_st_t cw_d, cw_q;
    logic   launch;

    always_comb begin
        cw_d        = cw_q;
        cw_d.kstart = 1'b0;
        done_evt    = cw_q.running && krn_done;
        launch      = cw_q.start && !cw_q.running;

        // pending start becomes a launch pulse; start bit self-clears
        if (launch) begin
            cw_d.kstart  = 1'b1;
            cw_d.running = 1'b1;
            cw_d.start   = 1'b0;
        end

        // run finishes; relaunch when auto-restart is on
        if (done_evt) begin
            cw_d.running = 1'b0;
            if (cw_q.auto_rs) cw_d.start = 1'b1;
        end

        // host write: only bit 0 and bit 7 are writable
        if (wr_ctrl) begin
            cw_d.auto_rs = wr_byte[CW_AUTO];
            if (wr_byte[CW_START] && !cw_q.running && !cw_q.start)
                cw_d.start = 1'b1;
        end

        // clear-on-read, a finish in the same cycle wins
        if (rd_ctrl)  cw_d.done = 1'b0;
        if (done_evt) cw_d.done = 1'b1;

        ready_evt = cw_q.running && !cw_d.running;

        ctrl_word           = '0;
        ctrl_word[CW_START] = cw_q.start;
        ctrl_word[CW_DONE]  = cw_q.done;
        ctrl_word[CW_IDLE]  = !cw_q.running;
        ctrl_word[CW_READY] = !cw_q.running;
        ctrl_word[CW_AUTO]  = cw_q.auto_rs;

        krn_start = cw_q.kstart;
        running   = cw_q.running;
        start_bit = cw_q.start;
        done_bit  = cw_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cw_q <= '0;
        else        cw_q <= cw_d;
    end

endmodule

// File: rtl/krn_irq_regs.sv
module krn_irq_regs #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_gie,
    input  logic             wr_ier,
    input  logic             wr_isr,
    input  logic [N_SRC-1:0] wr_bits,
    input  logic [N_SRC-1:0] evt,
    output logic             gie,
    output logic [N_SRC-1:0] ier,
    output logic [N_SRC-1:0] isr,
    output logic             irq
);

    typedef struct packed {
        logic             gie;
        logic [N_SRC-1:0] ier;
        logic [N_SRC-1:0] isr;
        logic             irq;
    } irq_st_t;

    irq_st_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        if (wr_gie) ir_d.gie = wr_bits[0];
        if (wr_ier) ir_d.ier = wr_bits;
        for (int i = 0; i < N_SRC; i++) begin
            // event set has priority over write-one-to-clear
            ir_d.isr[i] = (ir_q.isr[i] && !(wr_isr && wr_bits[i])) || evt[i];
        end
        ir_d.irq = ir_d.gie && (|(ir_d.ier & ir_d.isr));

        gie = ir_q.gie;
        ier = ir_q.ier;
        isr = ir_q.isr;
        irq = ir_q.irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

endmodule

// File: rtl/krn_ctrl_top.sv
module krn_ctrl_top #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic                krn_start,
    input  logic                krn_done,
    output logic                irq
);
    import krn_ctrl_pkg::*;

    // register window is 16 bytes; ADDR_W must be at least 5
    localparam int WIN_LSB = 4;

    logic                 wr_en, rd_en;
    logic [ADDR_W-1:0]    wr_addr, rd_addr;
    logic [DATA_W-1:0]    wr_data, rd_data, ctrl_word;
    logic                 wr_hit, rd_hit;
    reg_sel_e             wr_sel, rd_sel;
    logic                 wr_ctrl, wr_gie, wr_ier, wr_isr, rd_ctrl;
    logic                 running, start_bit, done_bit, done_evt, ready_evt;
    logic                 gie;
    logic [IRQ_SRC_N-1:0] ier, isr, irq_evt;

    krn_axil_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always_comb begin
        wr_hit  = (wr_addr[ADDR_W-1:WIN_LSB] == '0);
        rd_hit  = (rd_addr[ADDR_W-1:WIN_LSB] == '0);
        wr_sel  = reg_sel_e'(wr_addr[3:2]);
        rd_sel  = reg_sel_e'(rd_addr[3:2]);
        wr_ctrl = wr_en && wr_hit && (wr_sel == SEL_CTRL);
        wr_gie  = wr_en && wr_hit && (wr_sel == SEL_GIE);
        wr_ier  = wr_en && wr_hit && (wr_sel == SEL_IER);
        wr_isr  = wr_en && wr_hit && (wr_sel == SEL_ISR);
        rd_ctrl = rd_en && rd_hit && (rd_sel == SEL_CTRL);

        irq_evt                = '0;
        irq_evt[IRQ_SRC_DONE]  = done_evt;
        irq_evt[IRQ_SRC_READY] = ready_evt;

        rd_data = '0;
        if (rd_hit) begin
            case (rd_sel)
                SEL_CTRL: rd_data = ctrl_word;
                SEL_GIE:  rd_data[0] = gie;
                SEL_IER:  rd_data[IRQ_SRC_N-1:0] = ier;
                SEL_ISR:  rd_data[IRQ_SRC_N-1:0] = isr;
                default:  rd_data = '0;
            endcase
        end
    end

    krn_ctrl_word #(.DATA_W(DATA_W)) u_word (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_ctrl), .wr_byte(wr_data[7:0]), .rd_ctrl(rd_ctrl),
        .krn_done(krn_done), .krn_start(krn_start),
        .running(running), .start_bit(start_bit), .done_bit(done_bit),
        .done_evt(done_evt), .ready_evt(ready_evt), .ctrl_word(ctrl_word)
    );

    krn_irq_regs #(.N_SRC(IRQ_SRC_N)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_gie(wr_gie), .wr_ier(wr_ier), .wr_isr(wr_isr),
        .wr_bits(wr_data[IRQ_SRC_N-1:0]), .evt(irq_evt),
        .gie(gie), .ier(ier), .isr(isr), .irq(irq)
    );

endmodule

// File: rtl/krn_ctrl_chk.sv
module krn_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       krn_start,
    input logic       krn_done,
    input logic       irq,
    input logic       running,
    input logic       start_bit,
    input logic       done_bit,
    input logic       wr_ctrl,
    input logic       wr_isr,
    input logic [7:0] wbyte,
    input logic       gie,
    input logic [1:0] ier,
    input logic [1:0] isr,
    input logic       s_bvalid,
    input logic       s_bready
);

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        krn_start |=> !krn_start);

    p_start_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        krn_start |-> running);

    p_busy_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wbyte[0] && running && !krn_done) |=> !start_bit);

    p_done_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && krn_done) |=> done_bit);

    p_isr0_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (isr[0] && !(wr_isr && wbyte[0])) |=> isr[0]);

    p_isr1_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (isr[1] && !(wr_isr && wbyte[1])) |=> isr[1]);

    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && ((ier & isr) != 2'b00)));

    p_bresp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

endmodule

bind krn_ctrl_top krn_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .krn_start(krn_start), .krn_done(krn_done),
    .irq(irq), .running(running), .start_bit(start_bit), .done_bit(done_bit),
    .wr_ctrl(wr_ctrl), .wr_isr(wr_isr), .wbyte(wr_data[7:0]),
    .gie(gie), .ier(ier), .isr(isr), .s_bvalid(s_bvalid), .s_bready(s_bready)
);

// File: tb/tb_krn_ctrl_top.sv
module tb_krn_ctrl_top;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   s_awaddr = '0;
    logic                s_awvalid = 1'b0;
    logic                s_awready;
    logic [DATA_W-1:0]   s_wdata = '0;
    logic [DATA_W/8-1:0] s_wstrb = '1;
    logic                s_wvalid = 1'b0;
    logic                s_wready;
    logic [1:0]          s_bresp;
    logic                s_bvalid;
    logic                s_bready = 1'b1;
    logic [ADDR_W-1:0]   s_araddr = '0;
    logic                s_arvalid = 1'b0;
    logic                s_arready;
    logic [DATA_W-1:0]   s_rdata;
    logic [1:0]          s_rresp;
    logic                s_rvalid;
    logic                s_rready = 1'b1;
    logic                krn_start;
    logic                krn_done = 1'b0;
    logic                irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int run_len = 6;
    int starts_seen = 0;
    int dones_given = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];

    always #5 clk = ~clk;

    krn_ctrl_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

    // kernel model: runs for run_len cycles after each launch pulse
    initial begin
        forever begin
            @(negedge clk);
            if (krn_start) begin
                starts_seen++;
                repeat (run_len - 1) @(negedge clk);
                krn_done = 1'b1;
                @(negedge clk);
                krn_done = 1'b0;
                dones_given++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each returned read beat
    always @(negedge clk) begin
        if (rst_n && s_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected read beat", s_rdata, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(s_rdata === e && s_rresp == 2'b00, t, s_rdata, e);
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] strb = 4'hF);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = strb;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        @(negedge clk);
        s_arvalid = 1'b0;
    endtask

    task automatic wait_dones(input int n);
        wait (dones_given >= n);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        int d0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0 && krn_start == 1'b0, "R1 irq/start after reset", {30'b0, irq, krn_start}, 32'h0);
        rd(6'h00, 32'h0000000C, "R1 ctrl reset");
        rd(6'h04, 32'h0, "R1 gie reset");
        rd(6'h08, 32'h0, "R1 ier reset");
        rd(6'h0C, 32'h0, "R1 isr reset");

        // R12 write response
        @(negedge clk);
        s_awaddr = 6'h04; s_wdata = 32'h0; s_wstrb = 4'hF;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        check(s_bvalid == 1'b1 && s_bresp == 2'b00, "R12 write response", {30'b0, s_bresp}, 32'h0);

        // R2/R4 single launch; R3 done clear-on-read
        s0 = starts_seen; d0 = dones_given;
        run_len = 6;
        wr(6'h00, 32'h1);
        rd(6'h00, 32'h00000000, "R4 running, start cleared");
        wait_dones(d0 + 1);
        check(starts_seen == s0 + 1, "R2 one launch", starts_seen, s0 + 1);
        rd(6'h00, 32'h0000000E, "R3 done set, idle");
        rd(6'h00, 32'h0000000C, "R3 done cleared by read");

        // R5 start while busy ignored
        s0 = starts_seen; d0 = dones_given;
        run_len = 20;
        wr(6'h00, 32'h1);
        wait (starts_seen == s0 + 1);
        wr(6'h00, 32'h1);
        rd(6'h00, 32'h00000000, "R5 start bit stays 0 while busy");
        wait_dones(d0 + 1);
        repeat (10) @(negedge clk);
        check(starts_seen == s0 + 1, "R5 no extra launch", starts_seen, s0 + 1);
        rd(6'h00, 32'h0000000E, "R5 idle after run");
        rd(6'h00, 32'h0000000C, "R5 done cleared");

        // R6 auto-restart
        s0 = starts_seen;
        run_len = 5;
        wr(6'h00, 32'h81);
        wait (starts_seen >= s0 + 3);
        check(starts_seen >= s0 + 3, "R6 relaunch chain", starts_seen, s0 + 3);
        wr(6'h00, 32'h00);
        s0 = starts_seen;
        repeat (40) @(negedge clk);
        check(starts_seen == s0, "R6 no relaunch after clear", starts_seen, s0);
        rd(6'h00, 32'h0000000E, "R6 auto bit cleared, done set");
        rd(6'h00, 32'h0000000C, "R6 done cleared");

        // R7 unused bits and strobes
        s0 = starts_seen;
        wr(6'h00, 32'hFFFFFFF6);
        rd(6'h00, 32'h0000008C, "R7 only auto bit writable");
        wr(6'h00, 32'h00000000);
        wr(6'h00, 32'h00000001, 4'b1110);
        repeat (10) @(negedge clk);
        check(starts_seen == s0, "R7 masked strobe no launch", starts_seen, s0);
        rd(6'h00, 32'h0000000C, "R7 ctrl unchanged");

        // R8 enable registers
        wr(6'h0C, 32'h3);
        rd(6'h0C, 32'h0, "R9 isr cleared by write-one");
        wr(6'h08, 32'hFFFFFFFF);
        rd(6'h08, 32'h3, "R8 ier width");
        wr(6'h04, 32'hFFFFFFFF);
        rd(6'h04, 32'h1, "R8 gie width");
        wr(6'h04, 32'h0);

        // R9/R10 status latch and irq gating
        d0 = dones_given;
        run_len = 4;
        wr(6'h00, 32'h1);
        wait_dones(d0 + 1);
        rd(6'h0C, 32'h3, "R9 status latched with gie off");
        check(irq == 1'b0, "R10 irq low with gie off", irq, 0);
        rd(6'h00, 32'h0000000E, "R3 done after run");
        wr(6'h04, 32'h1);
        @(negedge clk);
        check(irq == 1'b1, "R10 irq high with gie on", irq, 1);
        wr(6'h0C, 32'h1);
        rd(6'h0C, 32'h2, "R9 clear done bit only");
        check(irq == 1'b1, "R10 irq from ready source", irq, 1);
        wr(6'h08, 32'h1);
        @(negedge clk);
        check(irq == 1'b0, "R10 irq low when source masked", irq, 0);
        wr(6'h0C, 32'h2);
        rd(6'h0C, 32'h0, "R9 clear ready bit");
        d0 = dones_given;
        wr(6'h00, 32'h1);
        wait_dones(d0 + 1);
        check(irq == 1'b1, "R10 irq on done event", irq, 1);
        wr(6'h0C, 32'h1);
        @(negedge clk);
        check(irq == 1'b0, "R10 irq drops after clear", irq, 0);
        wr(6'h04, 32'h0);

        // R11 out of range
        s0 = starts_seen;
        rd(6'h10, 32'h0, "R11 out of range read");
        wr(6'h10, 32'h1);
        wr(6'h20, 32'h1);
        repeat (10) @(negedge clk);
        check(starts_seen == s0, "R11 out of range write ignored", starts_seen, s0);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R12 all reads answered", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule